// File: doc/BRIEF.md
# Dual-Stream Trace Capture Buffer

This block is an on-chip trace recorder in the manner of a small logic analyzer. It watches two independent streams, a request stream and a response stream, and, while capture is switched on, stores every valid sample of each stream into that stream's own circular memory. Each stored entry is 192 bits wide, which is wider than the 32-bit register bus used to read it back.

Software controls and reads the recorder through four 32-bit registers: a control register, a status register and one data window per memory. The control register holds a read pointer for each memory and the capture enable bit. The status register reports where each stream will write next. To inspect a trace, software clears the enable bit so both memories stop changing. It then steps a read pointer through word addresses `8*entry + slice` and reads the entry from the matching data window, six 32-bit slices at a time.

Top module: `dual_trace_recorder`

## Requirements
- R1: While capture is enabled, each cycle with a stream's valid input high stores the full 192-bit sample at entry `write_pointer/8` of that stream's memory. The same cycle advances that stream's write pointer by 8, modulo `8*DEPTH` (512 at the default depth). Cycles with valid low leave the pointer unchanged.
- R2: While the enable bit is clear, valid samples are ignored. Neither write pointer moves, and no stored entry changes.
- R3: Control register (offset 0): request read pointer at bits 31:23, response read pointer at bits 22:14, capture enable at bit 12. One write updates all three in the same cycle. Pointer bits above the pointer width are ignored. A readback returns the three fields, with every other bit reading zero.
- R4: Status register (offset 1): request write pointer at bits 24:16 and response write pointer at bits 8:0. Every other bit reads zero.
- R5: Register offsets on `bus_addr` are 0 control, 1 status, 2 request window, 3 response window. Read data appears on `bus_rdata` one cycle after the read strobe and holds until the next read.
- R6: A data window returns slice `ptr[2:0]` of entry `ptr/8`, using its own read pointer. Slice 0 is sample bits 31:0 and slice 5 is sample bits 191:160.
- R7: Slices 6 and 7 of every entry read as zero.
- R8: An entry that has not been written since reset reads as zero in every slice.
- R9: After reset, capture is disabled, all read and write pointers are zero, and `bus_rdata` is zero.
- R10: The two streams are independent, and each may advance alone. When a stream wraps past its last entry, it overwrites its oldest entries.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request stream sample valid |
| req_data | input | ENTRY_W | Request stream sample |
| rsp_valid | input | 1 | Response stream sample valid |
| rsp_data | input | ENTRY_W | Response stream sample |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 2 | Register offset |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Register read data, one cycle after the read strobe |

## Verification
The bench builds the recorder with `DEPTH=16`, so each pointer is 7 bits wide and wraps at 128. With this depth, a run of a few dozen samples wraps the request memory and overwrites its oldest entries, while the response memory stays partly unwritten. The bench then sweeps all 128 word addresses of both windows. The sweep covers every slice, the two unused slices and the never-written entries, and checks each word against values the bench computes from its own sample numbering. The small pointer width also puts the ignored upper bits of the pointer fields within reach.

// File: rtl/trace_cap_pkg.sv
// Shared constants for the dual-stream trace recorder: register offsets and
// the bit positions of the control and status fields.
// Assumes a 32-bit register bus and pointers no wider than 9 bits.
package trace_cap_pkg;

    localparam int BUS_W      = 32;
    localparam int FIELD_W    = 9;   // widest pointer the register map holds
    localparam int SLOT_BITS  = 3;   // eight word addresses per entry

    localparam int CTL_RQ_LSB = 23;
    localparam int CTL_RS_LSB = 14;
    localparam int CTL_EN_BIT = 12;
    localparam int STS_RQ_LSB = 16;
    localparam int STS_RS_LSB = 0;

    typedef enum logic [1:0] {
        OFS_CTRL   = 2'd0,
        OFS_STATUS = 2'd1,
        OFS_RQ_WIN = 2'd2,
        OFS_RS_WIN = 2'd3
    } reg_ofs_e;

endpackage

// File: rtl/trace_ctrl_regs.sv
// Control register of the trace recorder: holds both read pointers and the
// capture enable, and forms the readback word.
// Assumes PTR_W <= trace_cap_pkg::FIELD_W. Pointer bits above PTR_W are dropped.
module trace_ctrl_regs
    import trace_cap_pkg::*;
#(
    parameter int PTR_W = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [BUS_W-1:0]  wr_data,
    output logic [PTR_W-1:0]  rq_rptr,
    output logic [PTR_W-1:0]  rs_rptr,
    output logic              cap_en,
    output logic [BUS_W-1:0]  ctrl_word
);

    logic unused_wdata;
    assign unused_wdata = ^wr_data;

    // Load all three fields together on a control write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rq_rptr <= '0;
            rs_rptr <= '0;
            cap_en  <= 1'b0;
        end else if (wr_en) begin
            rq_rptr <= wr_data[CTL_RQ_LSB +: PTR_W];
            rs_rptr <= wr_data[CTL_RS_LSB +: PTR_W];
            cap_en  <= wr_data[CTL_EN_BIT];
        end
    end

    // Place the fields at their register positions for readback.
    always_comb begin
        ctrl_word                          = '0;
        ctrl_word[CTL_RQ_LSB +: PTR_W]     = rq_rptr;
        ctrl_word[CTL_RS_LSB +: PTR_W]     = rs_rptr;
        ctrl_word[CTL_EN_BIT]              = cap_en;
    end

endmodule

// File: rtl/trace_store.sv
// One circular trace memory: captures a full entry per valid cycle while
// enabled, and offers a combinational 32-bit slice selected by a word pointer.
// Assumes DEPTH is a power of two and WORDS <= 8. Entries not written since
// reset read as zero.
module trace_store
    import trace_cap_pkg::*;
#(
    parameter int DEPTH   = 64,
    parameter int ENTRY_W = 192,
    parameter int WORDS   = 6,
    parameter int PTR_W   = 9
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cap_en,
    input  logic               in_valid,
    input  logic [ENTRY_W-1:0] in_data,
    input  logic [PTR_W-1:0]   rptr,
    output logic [PTR_W-1:0]   wptr,
    output logic [BUS_W-1:0]   rd_word
);

    localparam int IDX_W = PTR_W - SLOT_BITS;

    logic [ENTRY_W-1:0]   mem [DEPTH];
    logic [DEPTH-1:0]     filled;
    logic                 do_cap;
    logic [IDX_W-1:0]     w_idx;
    logic [IDX_W-1:0]     r_idx;
    logic [SLOT_BITS-1:0] r_slot;

    assign do_cap = cap_en && in_valid;
    assign w_idx  = wptr[PTR_W-1:SLOT_BITS];
    assign r_idx  = rptr[PTR_W-1:SLOT_BITS];
    assign r_slot = rptr[SLOT_BITS-1:0];

    // Store the sample into the entry under the write pointer.
    always_ff @(posedge clk) begin
        if (do_cap) begin
            mem[w_idx] <= in_data;
        end
    end

    // Advance the write pointer by one entry stride and mark the entry filled.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wptr   <= '0;
            filled <= '0;
        end else if (do_cap) begin
            wptr          <= wptr + PTR_W'(1 << SLOT_BITS);
            filled[w_idx] <= 1'b1;
        end
    end

    // Pick the addressed slice; unused slices and empty entries give zero.
    always_comb begin
        rd_word = '0;
        if (filled[r_idx] && (int'(r_slot) < WORDS)) begin
            rd_word = mem[r_idx][int'(r_slot)*BUS_W +: BUS_W];
        end
    end

endmodule

// File: rtl/dual_trace_recorder.sv
// Top of the dual-stream trace recorder: two trace memories, the control
// register and the registered read-data mux for the 32-bit register bus.
// Assumes ENTRY_W is a multiple of 32 with at most eight slices, and
// DEPTH a power of two no larger than 64.
module dual_trace_recorder
    import trace_cap_pkg::*;
#(
    parameter int DEPTH   = 64,
    parameter int ENTRY_W = 192
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req_valid,
    input  logic [ENTRY_W-1:0] req_data,
    input  logic               rsp_valid,
    input  logic [ENTRY_W-1:0] rsp_data,
    input  logic               bus_wr,
    input  logic               bus_rd,
    input  logic [1:0]         bus_addr,
    input  logic [BUS_W-1:0]   bus_wdata,
    output logic [BUS_W-1:0]   bus_rdata
);

    localparam int WORDS   = ENTRY_W / BUS_W;
    localparam int PTR_W   = $clog2(DEPTH) + SLOT_BITS;
    localparam int NSTREAM = 2;

    logic               s_valid [NSTREAM];
    logic [ENTRY_W-1:0] s_data  [NSTREAM];
    logic [PTR_W-1:0]   s_rptr  [NSTREAM];
    logic [PTR_W-1:0]   s_wptr  [NSTREAM];
    logic [BUS_W-1:0]   s_word  [NSTREAM];

    logic               cap_en;
    logic [BUS_W-1:0]   ctrl_word;
    logic [BUS_W-1:0]   status_word;

    assign s_valid[0] = req_valid;
    assign s_data[0]  = req_data;
    assign s_valid[1] = rsp_valid;
    assign s_data[1]  = rsp_data;

    trace_ctrl_regs #(.PTR_W(PTR_W)) i_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (bus_wr && (bus_addr == OFS_CTRL)),
        .wr_data   (bus_wdata),
        .rq_rptr   (s_rptr[0]),
        .rs_rptr   (s_rptr[1]),
        .cap_en    (cap_en),
        .ctrl_word (ctrl_word)
    );

    for (genvar s = 0; s < NSTREAM; s++) begin : g_stream
        trace_store #(
            .DEPTH   (DEPTH),
            .ENTRY_W (ENTRY_W),
            .WORDS   (WORDS),
            .PTR_W   (PTR_W)
        ) i_store (
            .clk      (clk),
            .rst_n    (rst_n),
            .cap_en   (cap_en),
            .in_valid (s_valid[s]),
            .in_data  (s_data[s]),
            .rptr     (s_rptr[s]),
            .wptr     (s_wptr[s]),
            .rd_word  (s_word[s])
        );
    end

    // Assemble the status word from both write pointers.
    always_comb begin
        status_word                      = '0;
        status_word[STS_RQ_LSB +: PTR_W] = s_wptr[0];
        status_word[STS_RS_LSB +: PTR_W] = s_wptr[1];
    end

    // Register the selected read data one cycle after the read strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bus_rdata <= '0;
        end else if (bus_rd) begin
            case (bus_addr)
                OFS_CTRL:   bus_rdata <= ctrl_word;
                OFS_STATUS: bus_rdata <= status_word;
                OFS_RQ_WIN: bus_rdata <= s_word[0];
                default:    bus_rdata <= s_word[1];
            endcase
        end
    end

endmodule

// File: rtl/dual_trace_recorder_chk.sv
// Property checker for the dual-stream trace recorder, bound to the top.
// Assumes the register map of trace_cap_pkg.
module dual_trace_recorder_chk
    import trace_cap_pkg::*;
#(
    parameter int PTR_W = 9,
    parameter int WORDS = 6
) (
    input logic             clk,
    input logic             rst_n,
    input logic             req_valid,
    input logic             rsp_valid,
    input logic             bus_wr,
    input logic             bus_rd,
    input logic [1:0]       bus_addr,
    input logic [BUS_W-1:0] bus_wdata,
    input logic [BUS_W-1:0] bus_rdata,
    input logic             cap_en,
    input logic [PTR_W-1:0] rq_rptr,
    input logic [PTR_W-1:0] rs_rptr,
    input logic [PTR_W-1:0] wptr_req,
    input logic [PTR_W-1:0] wptr_rsp
);

    assert_req_step_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (cap_en && req_valid) |=> (wptr_req == $past(wptr_req) + PTR_W'(8)));

    assert_rsp_step_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (cap_en && rsp_valid) |=> (wptr_rsp == $past(wptr_rsp) + PTR_W'(8)));

    assert_frozen_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!cap_en) |=> ($stable(wptr_req) && $stable(wptr_rsp)));

    assert_ctrl_load_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == 2'd0) |=>
            (rq_rptr == $past(bus_wdata[CTL_RQ_LSB +: PTR_W]) &&
             rs_rptr == $past(bus_wdata[CTL_RS_LSB +: PTR_W]) &&
             cap_en  == $past(bus_wdata[CTL_EN_BIT])));

    assert_status_read_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_addr == 2'd1) |=>
            (bus_rdata == ((32'($past(wptr_req)) << STS_RQ_LSB) |
                           (32'($past(wptr_rsp)) << STS_RS_LSB))));

    assert_hold_rdata_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!bus_rd) |=> $stable(bus_rdata));

    assert_gap_slice_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_addr == 2'd2 && int'(rq_rptr[2:0]) >= WORDS) |=>
            (bus_rdata == '0));

endmodule

bind dual_trace_recorder dual_trace_recorder_chk #(
    .PTR_W (PTR_W),
    .WORDS (WORDS)
) i_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .rsp_valid (rsp_valid),
    .bus_wr    (bus_wr),
    .bus_rd    (bus_rd),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .cap_en    (cap_en),
    .rq_rptr   (s_rptr[0]),
    .rs_rptr   (s_rptr[1]),
    .wptr_req  (s_wptr[0]),
    .wptr_rsp  (s_wptr[1])
);

// File: tb/test_dual_trace_recorder.sv
// Self-checking bench: small depth, near-exhaustive window sweep.
module test_dual_trace_recorder;

    localparam int CLK_PERIOD = 10;
    localparam int DEPTH      = 16;
    localparam int ENTRY_W    = 192;
    localparam int WORDS      = 6;
    localparam int SPAN       = DEPTH * 8;   // 128 word addresses

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               req_valid = 1'b0;
    logic [ENTRY_W-1:0] req_data = '0;
    logic               rsp_valid = 1'b0;
    logic [ENTRY_W-1:0] rsp_data = '0;
    logic               bus_wr = 1'b0;
    logic               bus_rd = 1'b0;
    logic [1:0]         bus_addr = 2'd0;
    logic [31:0]        bus_wdata = '0;
    logic [31:0]        bus_rdata;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    // bench model
    bit en_m = 1'b0;
    int wp_m  [2];
    int cnt_m [2];
    int num_m [2][DEPTH];
    bit fil_m [2][DEPTH];

    dual_trace_recorder #(.DEPTH(DEPTH), .ENTRY_W(ENTRY_W)) i_dual_trace_recorder (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_data(req_data),
        .rsp_valid(rsp_valid), .rsp_data(rsp_data),
        .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [31:0] pat(int s, int n, int k);
        return {4'(s + 1), 12'(n), 8'(k), 8'(n * 7 + k * 3)};
    endfunction

    function automatic logic [ENTRY_W-1:0] sample(int s, int n);
        logic [ENTRY_W-1:0] d;
        for (int k = 0; k < WORDS; k++) d[k*32 +: 32] = pat(s, n, k);
        return d;
    endfunction

    function automatic logic [31:0] exp_word(int s, int a);
        int e = a / 8;
        int k = a % 8;
        if (k >= WORDS || !fil_m[s][e]) return 32'h0;
        return pat(s, num_m[s][e], k);
    endfunction

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
        end
    endtask

    task automatic reg_write(logic [1:0] a, logic [31:0] d);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
        if (a == 2'd0) en_m = d[12];
    endtask

    task automatic reg_read(logic [1:0] a, output logic [31:0] d);
        bus_rd = 1'b1; bus_addr = a;
        @(negedge clk);
        bus_rd = 1'b0;
        d = bus_rdata;
    endtask

    task automatic cap_cycle(bit rv, bit sv);
        req_valid = rv; req_data = sample(0, cnt_m[0]);
        rsp_valid = sv; rsp_data = sample(1, cnt_m[1]);
        @(negedge clk);
        req_valid = 1'b0; rsp_valid = 1'b0;
        if (en_m) begin
            if (rv) begin
                num_m[0][wp_m[0]/8] = cnt_m[0]; fil_m[0][wp_m[0]/8] = 1'b1;
                wp_m[0] = (wp_m[0] + 8) % SPAN; cnt_m[0]++;
            end
            if (sv) begin
                num_m[1][wp_m[1]/8] = cnt_m[1]; fil_m[1][wp_m[1]/8] = 1'b1;
                wp_m[1] = (wp_m[1] + 8) % SPAN; cnt_m[1]++;
            end
        end
    endtask

    function automatic logic [31:0] exp_status();
        return (32'(wp_m[0]) << 16) | 32'(wp_m[1]);
    endfunction

    task automatic sweep(string tag);
        logic [31:0] v;
        for (int a = 0; a < SPAN; a++) begin
            reg_write(2'd0, (32'(a) << 23) | (32'(SPAN - 1 - a) << 14));
            reg_read(2'd2, v);
            check(((a % 8) >= WORDS) ? {tag, " R7 req"} : {tag, " R6 req"}, v, exp_word(0, a));
            reg_read(2'd3, v);
            check(((SPAN - 1 - a) % 8 >= WORDS) ? {tag, " R7 rsp"} : {tag, " R6 rsp"},
                  v, exp_word(1, SPAN - 1 - a));
        end
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            bad++; total++;
            $display("FAIL watchdog expired");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        for (int s = 0; s < 2; s++) begin
            wp_m[s] = 0; cnt_m[s] = 0;
            for (int e = 0; e < DEPTH; e++) begin num_m[s][e] = 0; fil_m[s][e] = 1'b0; end
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R9 reset state
        check("R9 rdata after reset", bus_rdata, 32'h0);
        reg_read(2'd0, v); check("R9 ctrl after reset", v, 32'h0);
        reg_read(2'd1, v); check("R9 status after reset", v, 32'h0);
        reg_read(2'd2, v); check("R8 req window empty", v, 32'h0);
        reg_read(2'd3, v); check("R8 rsp window empty", v, 32'h0);

        // R3 field placement and ignored upper pointer bits
        reg_write(2'd0, 32'hFFFF_FFFF);
        reg_read(2'd0, v);
        check("R3 ctrl readback", v, (32'h7F << 23) | (32'h7F << 14) | (32'h1 << 12));
        reg_write(2'd0, 32'h0000_1000);
        reg_read(2'd0, v); check("R3 enable only", v, 32'h0000_1000);

        // R5 read data holds between reads
        @(negedge clk);
        check("R5 rdata held", bus_rdata, 32'h0000_1000);

        // R1 R10 capture with distinct valid patterns, request wraps
        for (int i = 0; i < 30; i++) cap_cycle((i % 4) != 3, (i % 3) == 0);
        reg_read(2'd1, v); check("R1 R10 status after capture", v, exp_status());
        check("R4 status upper bits zero", v & ~((32'h7F << 16) | 32'h7F), 32'h0);

        // R2 disabled capture is ignored
        reg_write(2'd0, 32'h0);
        for (int i = 0; i < 5; i++) cap_cycle(1'b1, 1'b1);
        reg_read(2'd1, v); check("R2 status frozen", v, exp_status());

        // R6 R7 R8 R10 sweep both windows
        sweep("sweep1");

        // R10 only response stream advances
        reg_write(2'd0, 32'h0000_1000);
        for (int i = 0; i < 3; i++) cap_cycle(1'b0, 1'b1);
        reg_write(2'd0, 32'h0);
        reg_read(2'd1, v); check("R10 independent advance", v, exp_status());
        sweep("sweep2");

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule